// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This block sits beside the execute stage and decides, in the same cycle that an instruction is presented, whether that instruction may take effect. The predicate is a four-bit condition code in the top nibble of every 32-bit instruction word. It is evaluated against a four-flag status register (negative, zero, carry, overflow). The result is an execute-enable level and, for coprocessor-class instructions, an issue strobe toward the coprocessor.

The block also owns the flag register. Flags change on only two occasions. The first is an executing instruction with its set-flags bit at 1 whose ALU requests a flag write. The second is a direct status-register write. Because nothing else changes them, a predicate computed once stays valid across any number of intervening instructions that leave the set-flags bit at 0. Flags loaded by a status write are visible to the very next conditional instruction.

Top module: `cond_gate_unit`

## Requirements
- R1: While reset is asserted and after its release, all four flags read 0 until the first update.
- R2: The condition code is instruction bits 31:28. `exec_en_o` is the same-cycle combination of `instr_vld_i`, those four bits and the current flags.
- R3: Code 4'hE (always) enables a valid instruction whatever the flags are.
- R4: Code 4'hF (never) suppresses execution whatever the flags are.
- R5: The single-flag codes pass as follows: 0 when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0, 4 when N=1, 5 when N=0, 6 when V=1, 7 when V=0.
- R6: The compound codes pass as follows: 8 on C=1 and Z=0; 9 on C=0 or Z=1; A on N==V; B on N!=V; C on Z=0 and N==V; D on Z=1 or N!=V.
- R7: When a valid instruction passes its condition, bit 20 is 1 and `alu_flag_wr_i` is 1, the flags take `alu_flags_i` at the next rising edge. The 4-bit flag vectors are ordered {N,Z,C,V}, MSB first.
- R8: When bit 20 is 0, an ALU flag request is ignored and the flags hold their value.
- R9: A flag write from an instruction whose condition fails is discarded.
- R10: `sr_wr_i` loads `sr_data_i` ({N,Z,C,V}) into the flags at the next rising edge. It wins over an ALU update in the same cycle.
- R11: `cop_issue_o` is high only when `cop_class_i` is high and the instruction executes. A coprocessor instruction whose condition fails is never issued.
- R12: With `instr_vld_i` low, neither enable nor issue is raised and no ALU flag update happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction in execute |
| instr_vld_i | input | 1 | Instruction word is valid |
| alu_flags_i | input | 4 | New flags from the ALU, {N,Z,C,V} |
| alu_flag_wr_i | input | 1 | ALU requests a flag update |
| sr_wr_i | input | 1 | Direct status-register write |
| sr_data_i | input | 4 | Flag values for the direct write, {N,Z,C,V} |
| cop_class_i | input | 1 | Instruction is a coprocessor instruction |
| exec_en_o | output | 1 | Instruction may take effect |
| cop_issue_o | output | 1 | Present instruction to the coprocessor |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
Enable and issue are combinational, so they are due in the same cycle as the instruction. The bench drives on the falling edge and samples them shortly afterwards, before the next rising edge. Flag updates, from the ALU or the status port, are due one rising edge after the stimulus. The bench therefore reads the flags at the following falling edge. Each table vector first loads its flags through the status port, waits that one edge, and only then applies the instruction. A vector never depends on state from an earlier one.

// File: rtl/cgu_pkg.sv
package cgu_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cgu_flags_t;

    typedef enum logic [3:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cgu_cond_e;

endpackage

// File: rtl/cgu_cond_eval.sv
module cgu_cond_eval
    import cgu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  cgu_flags_t flags_i,
    output logic       pass_o
);

    logic n_eq_v;

    always_comb begin
        n_eq_v = (flags_i.n == flags_i.v);
        unique case (cgu_cond_e'(cond_i))
            CC_EQ:   pass_o =  flags_i.z;
            CC_NE:   pass_o = !flags_i.z;
            CC_CS:   pass_o =  flags_i.c;
            CC_CC:   pass_o = !flags_i.c;
            CC_MI:   pass_o =  flags_i.n;
            CC_PL:   pass_o = !flags_i.n;
            CC_VS:   pass_o =  flags_i.v;
            CC_VC:   pass_o = !flags_i.v;
            CC_HI:   pass_o =  flags_i.c && !flags_i.z;
            CC_LS:   pass_o = !flags_i.c ||  flags_i.z;
            CC_GE:   pass_o =  n_eq_v;
            CC_LT:   pass_o = !n_eq_v;
            CC_GT:   pass_o = !flags_i.z &&  n_eq_v;
            CC_LE:   pass_o =  flags_i.z || !n_eq_v;
            CC_AL:   pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cgu_flag_reg.sv
module cgu_flag_reg
    import cgu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_wr_i,
    input  cgu_flags_t sr_data_i,
    input  logic       alu_upd_i,
    input  cgu_flags_t alu_data_i,
    output cgu_flags_t flags_o
);

    typedef struct packed {
        cgu_flags_t flags;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sr_wr_i) begin
            st_d.flags = sr_data_i;
        end else if (alu_upd_i) begin
            st_d.flags = alu_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/cond_gate_unit.sv
module cond_gate_unit
    import cgu_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int SF_BIT   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               instr_vld_i,
    input  logic [3:0]         alu_flags_i,
    input  logic               alu_flag_wr_i,
    input  logic               sr_wr_i,
    input  logic [3:0]         sr_data_i,
    input  logic               cop_class_i,
    output logic               exec_en_o,
    output logic               cop_issue_o,
    output logic               flag_n_o,
    output logic               flag_z_o,
    output logic               flag_c_o,
    output logic               flag_v_o
);

    localparam int COND_MSB = INSTR_W - 1;
    localparam int COND_LSB = INSTR_W - 4;

    cgu_flags_t flags_q;
    logic       cond_pass;
    logic       exec_en;
    logic       alu_upd;
    logic       unused_instr_bits;

    assign unused_instr_bits = ^{instr_i[COND_LSB-1:SF_BIT+1], instr_i[SF_BIT-1:0]};

    cgu_cond_eval u_eval (
        .cond_i  (instr_i[COND_MSB:COND_LSB]),
        .flags_i (flags_q),
        .pass_o  (cond_pass)
    );

    assign exec_en = instr_vld_i && cond_pass;
    assign alu_upd = exec_en && instr_i[SF_BIT] && alu_flag_wr_i;

    cgu_flag_reg u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_wr_i    (sr_wr_i),
        .sr_data_i  (cgu_flags_t'(sr_data_i)),
        .alu_upd_i  (alu_upd),
        .alu_data_i (cgu_flags_t'(alu_flags_i)),
        .flags_o    (flags_q)
    );

    assign exec_en_o   = exec_en;
    assign cop_issue_o = exec_en && cop_class_i;
    assign flag_n_o    = flags_q.n;
    assign flag_z_o    = flags_q.z;
    assign flag_c_o    = flags_q.c;
    assign flag_v_o    = flags_q.v;

endmodule

// File: rtl/cgu_checker.sv
module cgu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic        instr_vld_i,
    input logic        alu_flag_wr_i,
    input logic        sr_wr_i,
    input logic [3:0]  sr_data_i,
    input logic        cop_class_i,
    input logic        exec_en_o,
    input logic        cop_issue_o,
    input logic        flag_n_o,
    input logic        flag_z_o,
    input logic        flag_c_o,
    input logic        flag_v_o
);

    logic [3:0] flags;
    assign flags = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};

    // R1: flags are clear while reset is asserted
    always_comb begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (flags == 4'h0);
        end
    end

    p_always_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld_i && instr_i[31:28] == 4'hE) |-> exec_en_o);

    p_never_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:28] == 4'hF) |-> !exec_en_o);

    p_eq_needs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:28] == 4'h0 && exec_en_o) |-> flag_z_o);

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_wr_i && (!instr_i[20] || !alu_flag_wr_i || !instr_vld_i)) |=> $stable(flags));

    p_status_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_i |=> (flags == $past(sr_data_i)));

    p_cop_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cop_issue_o |-> (exec_en_o && cop_class_i));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_vld_i |-> (!exec_en_o && !cop_issue_o));

endmodule

bind cond_gate_unit cgu_checker u_cgu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr_i),
    .instr_vld_i   (instr_vld_i),
    .alu_flag_wr_i (alu_flag_wr_i),
    .sr_wr_i       (sr_wr_i),
    .sr_data_i     (sr_data_i),
    .cop_class_i   (cop_class_i),
    .exec_en_o     (exec_en_o),
    .cop_issue_o   (cop_issue_o),
    .flag_n_o      (flag_n_o),
    .flag_z_o      (flag_z_o),
    .flag_c_o      (flag_c_o),
    .flag_v_o      (flag_v_o)
);

// File: tb/cond_gate_unit_test.sv
`timescale 1ns/1ps
module cond_gate_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic        instr_vld_i = 1'b0;
    logic [3:0]  alu_flags_i = '0;
    logic        alu_flag_wr_i = 1'b0;
    logic        sr_wr_i = 1'b0;
    logic [3:0]  sr_data_i = '0;
    logic        cop_class_i = 1'b0;
    logic        exec_en_o, cop_issue_o;
    logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cond_gate_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_vld_i(instr_vld_i),
        .alu_flags_i(alu_flags_i), .alu_flag_wr_i(alu_flag_wr_i),
        .sr_wr_i(sr_wr_i), .sr_data_i(sr_data_i), .cop_class_i(cop_class_i),
        .exec_en_o(exec_en_o), .cop_issue_o(cop_issue_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
    );

    // {flags N,Z,C,V ; condition ; expected enable}
    localparam logic [8:0] VEC [25] = '{
        {4'b0100, 4'h0, 1'b1}, {4'b0000, 4'h0, 1'b0},
        {4'b0000, 4'h1, 1'b1}, {4'b0100, 4'h1, 1'b0},
        {4'b0010, 4'h2, 1'b1}, {4'b0010, 4'h3, 1'b0},
        {4'b1000, 4'h4, 1'b1}, {4'b1000, 4'h5, 1'b0},
        {4'b0001, 4'h6, 1'b1}, {4'b0000, 4'h7, 1'b1},
        {4'b0010, 4'h8, 1'b1}, {4'b0110, 4'h8, 1'b0},
        {4'b0110, 4'h9, 1'b1}, {4'b0010, 4'h9, 1'b0},
        {4'b1001, 4'hA, 1'b1}, {4'b1000, 4'hA, 1'b0},
        {4'b1000, 4'hB, 1'b1}, {4'b0000, 4'hC, 1'b1},
        {4'b0100, 4'hC, 1'b0}, {4'b1001, 4'hD, 1'b0},
        {4'b0001, 4'hD, 1'b1}, {4'b0000, 4'hE, 1'b1},
        {4'b1111, 4'hE, 1'b1}, {4'b1111, 4'hF, 1'b0},
        {4'b0000, 4'hF, 1'b0}
    };

    function automatic logic [3:0] rd_flags();
        return {flag_n_o, flag_z_o, flag_c_o, flag_v_o};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_flags(input logic [3:0] f);
        @(negedge clk);
        instr_vld_i = 1'b0;
        sr_wr_i = 1'b1;
        sr_data_i = f;
        @(negedge clk);
        sr_wr_i = 1'b0;
    endtask

    task automatic issue(input logic [3:0] cc, input logic sbit, input logic vld,
                         input logic cop, input logic aw, input logic [3:0] af);
        instr_i = {cc, 7'h00, sbit, 20'h12345};
        instr_vld_i = vld;
        cop_class_i = cop;
        alu_flag_wr_i = aw;
        alu_flags_i = af;
    endtask

    task automatic idle();
        instr_vld_i = 1'b0;
        alu_flag_wr_i = 1'b0;
        cop_class_i = 1'b0;
        sr_wr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        issue(4'hE, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF);
        #5;
        check("R1 flags in reset", {4'h0, rd_flags()}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        @(negedge clk);
        check("R1 flags after reset", {4'h0, rd_flags()}, 8'h00);

        // R2 R3 R4 R5 R6 R10 R11: table walk
        foreach (VEC[i]) begin
            load_flags(VEC[i][8:5]);
            check("R10 status load", {4'h0, rd_flags()}, {4'h0, VEC[i][8:5]});
            issue(VEC[i][4:1], 1'b0, 1'b1, 1'b1, 1'b0, 4'h0);
            #1;
            check((VEC[i][4:1] >= 4'h8) ? "R6 compound cond" :
                  (VEC[i][4:1] == 4'hE) ? "R3 always" :
                  (VEC[i][4:1] == 4'hF) ? "R4 never" : "R5 single-flag cond",
                  {7'h0, exec_en_o}, {7'h0, VEC[i][0]});
            check("R11 cop issue", {7'h0, cop_issue_o}, {7'h0, VEC[i][0]});
            @(negedge clk);
            idle();
        end

        // R7: executing set-flags instruction updates flags
        load_flags(4'b0000);
        issue(4'hE, 1'b1, 1'b1, 1'b0, 1'b1, 4'b1010);
        @(negedge clk);
        idle();
        check("R7 alu update", {4'h0, rd_flags()}, 8'h0A);

        // R8: set-flags bit clear, several instructions, flags held
        for (int k = 0; k < 3; k++) begin
            issue(4'hE, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0101);
            @(negedge clk);
        end
        idle();
        check("R8 no S bit hold", {4'h0, rd_flags()}, 8'h0A);
        issue(4'hB, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
        #1;
        check("R8 predicate survives (LT)", {7'h0, exec_en_o}, 8'h01);
        @(negedge clk);

        // R9: failed condition discards the write (EQ with Z=0)
        issue(4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0101);
        #1;
        check("R11 failed cop not issued", {7'h0, cop_issue_o}, 8'h00);
        @(negedge clk);
        idle();
        check("R9 failed cond discard", {4'h0, rd_flags()}, 8'h0A);

        // R10: status write wins over ALU update in the same cycle
        issue(4'hE, 1'b1, 1'b1, 1'b0, 1'b1, 4'b1100);
        sr_wr_i = 1'b1;
        sr_data_i = 4'b0011;
        @(negedge clk);
        idle();
        check("R10 status priority", {4'h0, rd_flags()}, 8'h03);

        // R12: invalid instruction does nothing
        issue(4'hE, 1'b1, 1'b0, 1'b1, 1'b1, 4'b1111);
        #1;
        check("R12 no enable", {7'h0, exec_en_o}, 8'h00);
        check("R12 no issue", {7'h0, cop_issue_o}, 8'h00);
        @(negedge clk);
        idle();
        check("R12 flags held", {4'h0, rd_flags()}, 8'h03);

        // R2: condition comes from the top nibble only, loaded flags visible at once
        load_flags(4'b0100);
        issue(4'h1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
        instr_i[27:0] = 28'hFFFFFFF;
        #1;
        check("R2 top nibble NE with Z=1", {7'h0, exec_en_o}, 8'h00);
        @(negedge clk);
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule